// File: doc/BRIEF.md
# Session-Table Accumulator Pattern Sequencer

This block produces test stimulus from an accumulator that is run in a fixed series of sessions. A constant table, set by parameters, holds one triplet per session: a start value, an increment and a pattern count. After a start pulse the sequencer walks the table in index order. For each session it loads the start value into the accumulator, presents it, and then adds the increment once per clock. It ends the session after the stated number of patterns and then fetches the next triplet.

Each pattern is flagged valid and tagged with the index of the session that produced it. When the last session has finished, a done flag is raised and held. The next start pulse returns the block to idle, and a further pulse runs the whole table again. The add wraps at the accumulator width. A session whose count is zero gives no patterns and is passed over.

Top module: `acc_triplet_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `pat_vld_o` and `done_o` are 0 and `sess_o` is 0.
- R2: A start pulse in idle runs the sessions in ascending index order from 0 to NUM_SESS-1, and `sess_o` carries the index of the running session on every valid cycle.
- R3: The first valid pattern of session k equals the start value of entry k.
- R4: Each later valid pattern of a session equals the previous pattern plus that session's increment, modulo 2^WIDTH, with no carry kept.
- R5: `pat_vld_o` is high for exactly L_k contiguous cycles in session k, where L_k is the count of entry k.
- R6: A session with a count of 0 produces no valid cycle, and the sequencer moves on to the next entry.
- R7: `done_o` rises in the cycle after the last valid pattern of the run and stays high until a start pulse. That pulse returns the block to idle, with `done_o` low in the next cycle and no patterns produced.
- R8: A start pulse while sessions are running has no effect on the pattern stream.
- R9: Table entry k sits at bits [k*WIDTH +: WIDTH] of START_TBL and INCR_TBL and at bits [k*LEN_W +: LEN_W] of LEN_TBL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse: begins a run from idle, or clears done |
| pat_o | output | WIDTH | Accumulator pattern |
| pat_vld_o | output | 1 | Pattern on `pat_o` is valid |
| sess_o | output | SESS_W | Index of the current session |
| done_o | output | 1 | All sessions finished |

## Verification
The last pattern of a session can land in the same cycle as the first one. When that happens, loading the start value and advancing or finishing the session coincide. The default table therefore ends with a one-pattern session, so that session's start value is also its final pattern and the trigger for done. A skipped zero-count entry sits just before it. The scoreboard checks that this one pattern carries the right value and index, and that done rises in the following cycle with nothing left in the queue.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } acc_cmd_t;

    function automatic logic is_zero_len(input logic [31:0] len);
        return len == 32'd0;
    endfunction

endpackage

// File: rtl/triplet_rom.sv
module triplet_rom #(
    parameter int WIDTH    = 8,
    parameter int NUM_SESS = 4,
    parameter int LEN_W    = 3,
    parameter int SESS_W   = 2,
    parameter logic [NUM_SESS*WIDTH-1:0] START_TBL = '0,
    parameter logic [NUM_SESS*WIDTH-1:0] INCR_TBL  = '0,
    parameter logic [NUM_SESS*LEN_W-1:0] LEN_TBL   = '0
) (
    input  logic [SESS_W-1:0] idx_i,
    output logic [WIDTH-1:0]  start_o,
    output logic [WIDTH-1:0]  incr_o,
    output logic [LEN_W-1:0]  len_o
);
    logic [WIDTH-1:0] start_arr [NUM_SESS];
    logic [WIDTH-1:0] incr_arr  [NUM_SESS];
    logic [LEN_W-1:0] len_arr   [NUM_SESS];

    for (genvar k = 0; k < NUM_SESS; k++) begin : g_entry
        assign start_arr[k] = START_TBL[k*WIDTH +: WIDTH];   // R9 layout
        assign incr_arr[k]  = INCR_TBL[k*WIDTH +: WIDTH];
        assign len_arr[k]   = LEN_TBL[k*LEN_W +: LEN_W];
    end

    always_comb begin
        start_o = '0;
        incr_o  = '0;
        len_o   = '0;
        for (int k = 0; k < NUM_SESS; k++) begin
            if (idx_i == SESS_W'(k)) begin
                start_o = start_arr[k];
                incr_o  = incr_arr[k];
                len_o   = len_arr[k];
            end
        end
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_seq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  acc_cmd_t         cmd_i,
    input  logic [WIDTH-1:0] start_val_i,
    input  logic [WIDTH-1:0] incr_i,
    output logic [WIDTH-1:0] acc_o
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] sum;

    assign sum = acc_q + incr_i;   // wraps modulo 2^WIDTH

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
        end else if (cmd_i.load) begin
            acc_q <= start_val_i;
        end else if (cmd_i.step) begin
            acc_q <= sum;
        end
    end

    assign acc_o = acc_q;

    p_load_start_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i.load |=> acc_q == $past(start_val_i));

    p_step_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i.step && !cmd_i.load) |=> acc_q == WIDTH'($past(acc_q) + $past(incr_i)));

    p_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmd_i.step && !cmd_i.load) |=> $stable(acc_q));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import acc_seq_pkg::*;
#(
    parameter int NUM_SESS = 4,
    parameter int LEN_W    = 3,
    parameter int SESS_W   = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [SESS_W-1:0] sess_o,
    output acc_cmd_t          cmd_o,
    output logic              vld_o,
    output logic              done_o
);
    localparam logic [SESS_W-1:0] LAST_IDX = SESS_W'(NUM_SESS - 1);

    seq_state_e        state_q;
    logic [SESS_W-1:0] sess_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              is_last;
    logic              len_zero;

    assign is_last  = (sess_q == LAST_IDX);
    assign len_zero = is_zero_len(32'(len_i));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            sess_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        sess_q  <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (len_zero) begin                // R6 skip
                        if (is_last) state_q <= ST_DONE;
                        else         sess_q  <= sess_q + 1'b1;
                    end else begin
                        cnt_q   <= len_i - 1'b1;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        if (is_last) begin
                            state_q <= ST_DONE;
                        end else begin
                            sess_q  <= sess_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DONE: begin
                    if (start_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o.load = (state_q == ST_LOAD) && !len_zero;
        cmd_o.step = (state_q == ST_RUN) && (cnt_q != '0);
    end

    assign vld_o  = (state_q == ST_RUN);
    assign done_o = (state_q == ST_DONE);
    assign sess_o = sess_q;

    p_sess_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && cnt_q != '0) |=> $stable(sess_q));

    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN) |-> (cnt_q < len_i));

    p_skip_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOAD && len_zero) |=> state_q != ST_RUN);

    p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DONE && !start_i) |=> state_q == ST_DONE);

    p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && cnt_q != '0 && start_i) |=> state_q == ST_RUN);
endmodule

// File: rtl/acc_triplet_seq.sv
module acc_triplet_seq
    import acc_seq_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NUM_SESS = 4,
    parameter int LEN_W    = 3,
    parameter logic [NUM_SESS*WIDTH-1:0] START_TBL = 32'hAA55_F010,
    parameter logic [NUM_SESS*WIDTH-1:0] INCR_TBL  = 32'h1101_0703,
    parameter logic [NUM_SESS*LEN_W-1:0] LEN_TBL   = 12'h223,
    localparam int SESS_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    output logic [WIDTH-1:0]  pat_o,
    output logic              pat_vld_o,
    output logic [SESS_W-1:0] sess_o,
    output logic              done_o
);
    logic [SESS_W-1:0] sess;
    logic [WIDTH-1:0]  tbl_start;
    logic [WIDTH-1:0]  tbl_incr;
    logic [LEN_W-1:0]  tbl_len;
    acc_cmd_t          cmd;

    triplet_rom #(
        .WIDTH(WIDTH), .NUM_SESS(NUM_SESS), .LEN_W(LEN_W), .SESS_W(SESS_W),
        .START_TBL(START_TBL), .INCR_TBL(INCR_TBL), .LEN_TBL(LEN_TBL)
    ) u_rom (
        .idx_i   (sess),
        .start_o (tbl_start),
        .incr_o  (tbl_incr),
        .len_o   (tbl_len)
    );

    seq_ctrl #(
        .NUM_SESS(NUM_SESS), .LEN_W(LEN_W), .SESS_W(SESS_W)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .len_i   (tbl_len),
        .sess_o  (sess),
        .cmd_o   (cmd),
        .vld_o   (pat_vld_o),
        .done_o  (done_o)
    );

    acc_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cmd_i       (cmd),
        .start_val_i (tbl_start),
        .incr_i      (tbl_incr),
        .acc_o       (pat_o)
    );

    assign sess_o = sess;

    p_vld_not_done_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (pat_vld_o && $past(pat_vld_o) && sess_o == $past(sess_o)) |-> !done_o);
endmodule

// File: tb/tb_acc_triplet_seq.sv
module tb_acc_triplet_seq;
    localparam int W  = 8;
    localparam int NS = 4;
    localparam int LW = 3;
    localparam int SW = 2;
    localparam logic [NS*W-1:0]  S_TBL = 32'hAA55_F010;
    localparam logic [NS*W-1:0]  I_TBL = 32'h1101_0703;
    localparam logic [NS*LW-1:0] L_TBL = 12'h223;

    typedef struct packed {
        logic [SW-1:0] sess;
        logic [W-1:0]  pat;
        logic          first;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [W-1:0]  pat;
    logic          vld;
    logic [SW-1:0] sess;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic mon_en = 1'b0;
    logic prev_vld = 1'b0;
    logic prev_done = 1'b0;
    exp_t expq[$];

    always #5 clk = ~clk;

    acc_triplet_seq #(
        .WIDTH(W), .NUM_SESS(NS), .LEN_W(LW),
        .START_TBL(S_TBL), .INCR_TBL(I_TBL), .LEN_TBL(L_TBL)
    ) dut (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .pat_o(pat), .pat_vld_o(vld), .sess_o(sess), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: expected stream from the table (R9 layout)
    task automatic push_run();
        for (int k = 0; k < NS; k++) begin
            logic [W-1:0] v;
            int l;
            v = S_TBL[k*W +: W];
            l = int'(L_TBL[k*LW +: LW]);
            for (int j = 0; j < l; j++) begin
                expq.push_back('{sess: SW'(k), pat: v, first: (j == 0)});
                v = v + I_TBL[k*W +: W];
            end
        end
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk) start = 1'b1;
        repeat (n) @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_en) begin
            if (vld) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R6/R8 unexpected valid", int'(pat), 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(sess == e.sess, "R2 session index", int'(sess), int'(e.sess));
                    if (e.first)
                        check(pat == e.pat, "R3 start value", int'(pat), int'(e.pat));
                    else begin
                        check(pat == e.pat, "R4 increment", int'(pat), int'(e.pat));
                        check(prev_vld, "R5 contiguous valid", int'(prev_vld), 1);
                    end
                end
            end
            if (done && !prev_done) begin
                check(prev_vld, "R7 done after last pattern", int'(prev_vld), 1);
                check(expq.size() == 0, "R5 all patterns seen", expq.size(), 0);
            end
        end
        prev_vld  <= vld;
        prev_done <= done;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL R7 watchdog done actual=%0d expected=1", done);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(vld == 1'b0, "R1 reset vld", int'(vld), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(sess == '0, "R1 reset sess", int'(sess), 0);
        @(negedge clk) rst = 1'b0;
        check(vld == 1'b0 && done == 1'b0 && sess == '0, "R1 after reset",
              int'({vld, done}), 0);
        mon_en = 1'b1;

        // run 1: single start pulse
        push_run();
        pulse_start(1);
        wait_done();
        check(sess == SW'(NS - 1), "R2 last index at done", int'(sess), NS - 1);
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R7 done held", int'(done), 1);

        // clear done: back to idle, no patterns
        pulse_start(1);
        check(done == 1'b0, "R7 done cleared", int'(done), 0);
        repeat (8) begin
            @(negedge clk);
            check(vld == 1'b0 && done == 1'b0, "R7 idle after clear", int'({vld, done}), 0);
        end

        // run 2: start held for several cycles (ignored after launch)
        push_run();
        pulse_start(3);
        wait_done();
        repeat (2) @(negedge clk);
        pulse_start(1);
        repeat (2) @(negedge clk);

        // run 3: start pulses sprinkled while sessions run
        push_run();
        pulse_start(1);
        repeat (2) @(negedge clk);
        pulse_start(1);
        repeat (3) @(negedge clk);
        pulse_start(1);
        @(negedge clk);
        pulse_start(1);
        wait_done();
        check(expq.size() == 0, "R8 stream intact", expq.size(), 0);
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule